// File: doc/BRIEF.md
# Per-Lane Metaframe CRC-32 Inserter

This block sits on one lane of the transmit path, between the metaframe builder and the scrambler. Each 67-bit block arrives on a valid/ready stream with a two-bit sideband tag that says what kind of word it is. The block keeps a running CRC-32 over every word of the current metaframe. It restarts that CRC on the synchronization word that opens each metaframe. When the diagnostic word arrives, the block writes the inverted CRC into that word's check field before sending it on.

Certain fields never reach the CRC. These are the three top header bits of every block, the scrambler state bits of the scrambler state word, and the check field of the diagnostic word. Masked bits are fed in as zeros, so every accepted word costs exactly one 64-bit parallel CRC step. The output goes through one register stage. Downstream ready is wired straight back to the upstream side, so a stall holds both ends and no word is lost or repeated.

Top module: `metaframe_crc_inserter`

## Requirements
- R1: While reset is asserted, and after its release until the first word is accepted, `out_valid` is 0.
- R2: `in_ready` equals `out_ready` in every cycle.
- R3: A word is accepted when `in_valid` and `out_ready` are both 1 at a clock edge. It appears on `out_valid`/`out_data` after exactly that edge, and words leave in the order they arrived. An edge with `out_ready` high and `in_valid` low leaves `out_valid` at 0.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R5: Words whose tag is not 3 (0 = payload or other, 1 = synchronization, 2 = scrambler state) leave with all 67 bits unchanged.
- R6: A word tagged 3 (diagnostic) leaves with bits [66:32] unchanged and bits [31:0] replaced by the bitwise inverse of the CRC register value after that word has been absorbed.
- R7: The CRC uses generator polynomial 0x1EDC6F41, non-reflected. Data bit 63 goes in first. The register is set to all ones before a synchronization word is absorbed, so words before the first synchronization word do not affect the next diagnostic result.
- R8: Bits [66:64] of every word do not affect the CRC.
- R9: In a scrambler state word, bits [57:0] do not affect the CRC; bits [63:58] do.
- R10: In a diagnostic word, bits [31:0] do not affect the CRC; bits [63:32] do.
- R11: Every bit in [63:0] of payload and synchronization words affects the CRC.
- R12: Cycles without an accepted word (idle input or backpressure) do not affect the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_kind | input | 2 | Word tag: 0 payload/other, 1 sync, 2 scrambler state, 3 diagnostic |
| in_data | input | 67 | Incoming block, bits [66:64] header, [63:0] body |
| out_valid | output | 1 | Outgoing word present |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | 67 | Outgoing block with the CRC inserted on diagnostic words |

## Verification
The properties assume that `in_kind` and `in_data` are known whenever `in_valid` is high. They also assume the upstream side follows the usual stream rule: a word offered is held until it is taken. The bench changes its inputs only at the falling edge. It keeps a word and its tag steady until the sampled `in_ready` shows the word was taken. The bench sweeps metaframe lengths and backpressure levels, and it flips bits inside and outside the masked fields to show which bits reach the CRC.

// File: rtl/crc_ins_pkg.sv
// Shared tags and default widths for the metaframe CRC inserter.
// Assumes the framing builder supplies one tag per word.
package crc_ins_pkg;

    typedef enum logic [1:0] {
        WK_DATA  = 2'd0,
        WK_SYNC  = 2'd1,
        WK_SCRAM = 2'd2,
        WK_DIAG  = 2'd3
    } word_kind_e;

    localparam int unsigned HDR_BITS  = 3;
    localparam int unsigned BODY_BITS = 64;
    localparam int unsigned CHK_BITS  = 32;
    localparam int unsigned SCR_BITS  = 58;

endpackage

// File: rtl/crc_field_mask.sv
// Zeroes the body bits that are excluded from the CRC for the given word kind.
// Assumes the scrambler state sits in the low SCR_W bits and the check field
// in the low CRC_W bits of their words.
module crc_field_mask
    import crc_ins_pkg::*;
#(
    parameter int unsigned DATA_W = BODY_BITS,
    parameter int unsigned SCR_W  = SCR_BITS,
    parameter int unsigned CRC_W  = CHK_BITS
) (
    input  word_kind_e         kind,
    input  logic [DATA_W-1:0]  body,
    output logic [DATA_W-1:0]  masked
);

    localparam logic [DATA_W-1:0] SCR_KEEP = {{(DATA_W-SCR_W){1'b1}}, {SCR_W{1'b0}}};
    localparam logic [DATA_W-1:0] CHK_KEEP = {{(DATA_W-CRC_W){1'b1}}, {CRC_W{1'b0}}};

    // Select the keep mask for the word kind and apply it.
    always_comb begin
        unique case (kind)
            WK_SCRAM: masked = body & SCR_KEEP;
            WK_DIAG:  masked = body & CHK_KEEP;
            default:  masked = body;
        endcase
    end

endmodule

// File: rtl/crc_par_step.sv
// One parallel CRC step over DATA_W bits, MSB first, non-reflected.
// Assumes POLY is written without its top term.
module crc_par_step #(
    parameter int unsigned      CRC_W  = 32,
    parameter int unsigned      DATA_W = 64,
    parameter logic [CRC_W-1:0] POLY   = 32'h1EDC6F41
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);

    // Unrolled bit-serial shift folded into one combinational step.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/crc_span_accum.sv
// Running CRC register for one metaframe. It restarts from INIT on a
// synchronization word and advances only on accepted words.
// Assumes body bits are already masked.
module crc_span_accum #(
    parameter int unsigned      CRC_W  = 32,
    parameter int unsigned      DATA_W = 64,
    parameter logic [CRC_W-1:0] POLY   = 32'h1EDC6F41,
    parameter logic [CRC_W-1:0] INIT   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              restart,
    input  logic [DATA_W-1:0] masked,
    output logic [CRC_W-1:0]  crc_next
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;

    // Choose the starting value: fresh on sync, running otherwise.
    always_comb seed = restart ? INIT : crc_q;

    crc_par_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
        .crc_in (seed),
        .data   (masked),
        .crc_out(crc_next)
    );

    // Hold the running CRC; update only on an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= INIT;
        else if (take) crc_q <= crc_next;
    end

endmodule

// File: rtl/metaframe_crc_inserter.sv
// Per-lane metaframe CRC-32 inserter. It absorbs each accepted word into a
// running CRC and writes the inverted result into the low check field of the
// diagnostic word. One output register stage; ready is passed straight upstream.
// Assumes in_kind is valid with in_data, and metaframes open with a sync word.
module metaframe_crc_inserter
    import crc_ins_pkg::*;
#(
    parameter int unsigned      HDR_W  = HDR_BITS,
    parameter int unsigned      DATA_W = BODY_BITS,
    parameter int unsigned      CRC_W  = CHK_BITS,
    parameter int unsigned      SCR_W  = SCR_BITS,
    parameter logic [CRC_W-1:0] POLY   = 32'h1EDC6F41
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_kind,
    input  logic [HDR_W+DATA_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [HDR_W+DATA_W-1:0] out_data
);

    localparam int unsigned WORD_W = HDR_W + DATA_W;

    word_kind_e         kind;
    logic               take;
    logic [DATA_W-1:0]  masked;
    logic [CRC_W-1:0]   crc_next;
    logic [WORD_W-1:0]  ins_word;

    // Decode the tag and the handshake.
    always_comb begin
        kind     = word_kind_e'(in_kind);
        in_ready = out_ready;
        take     = in_valid && out_ready;
    end

    crc_field_mask #(.DATA_W(DATA_W), .SCR_W(SCR_W), .CRC_W(CRC_W)) u_mask (
        .kind  (kind),
        .body  (in_data[DATA_W-1:0]),
        .masked(masked)
    );

    crc_span_accum #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .INIT('1)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .restart (kind == WK_SYNC),
        .masked  (masked),
        .crc_next(crc_next)
    );

    // Replace the check field on diagnostic words; pass others through.
    always_comb begin
        ins_word = in_data;
        if (kind == WK_DIAG) ins_word[CRC_W-1:0] = ~crc_next;
    end

    // Output stage: advance when downstream is ready, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (out_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= ins_word;
        end
    end

endmodule

// File: rtl/metaframe_crc_inserter_chk.sv
// Protocol checks on the inserter's ports, attached with bind.
// Assumes the upstream side holds in_kind/in_data known while in_valid is high.
module metaframe_crc_inserter_chk #(
    parameter int unsigned WORD_W = 67
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_kind,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R3

    AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && out_ready |=> !out_valid); // R3

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_kind != 2'd3 |=> out_data == $past(in_data)); // R5

    AST_DIAG_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_kind == 2'd3 |=> out_data[WORD_W-1:32] == $past(in_data[WORD_W-1:32])); // R6

endmodule

bind metaframe_crc_inserter metaframe_crc_inserter_chk #(.WORD_W(HDR_W + DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_kind  (in_kind),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tb_metaframe_crc_inserter.sv
module tb_metaframe_crc_inserter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'd0;
    logic [66:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [66:0] out_data;

    always #2 clk = ~clk;  // 250 MHz

    metaframe_crc_inserter dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [63:0] rs = 64'h9E3779B97F4A7C15;
    int          stall_pct = 0;
    logic [31:0] ref_crc = '1;
    logic [66:0] exp_d [0:4095];
    logic [1:0]  exp_k [0:4095];
    int          wr = 0;
    int          rd = 0;
    bit          prev_stall = 0;
    logic [66:0] prev_data = '0;
    logic [31:0] last_field = '0;
    logic [66:0] fw [0:15];
    logic [1:0]  fk [0:15];
    logic [66:0] bw [0:15];
    int          flen = 0;

    function automatic logic [63:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    // Reference CRC-32C step, MSB first, from R7
    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [63:0] d);
        logic [31:0] a = c;
        for (int i = 63; i >= 0; i--) begin
            logic f = a[31] ^ d[i];
            a = {a[30:0], 1'b0} ^ (f ? 32'h1EDC6F41 : 32'h0);
        end
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [66:0] act, input logic [66:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [1:0] k, input logic [66:0] d, output bit took);
        logic [63:0] m;
        logic [31:0] nx;
        @(negedge clk);
        out_ready = (rnd() % 100) >= 64'(stall_pct);
        in_valid = v; in_kind = k; in_data = d;
        #1;
        chk(in_ready === out_ready, "R2", 67'(in_ready), 67'(out_ready));
        if (prev_stall)
            chk(out_valid === 1'b1 && out_data === prev_data, "R4", out_data, prev_data);
        if (out_valid && out_ready) begin
            if (rd == wr) chk(1'b0, "R3 unexpected output", out_data, '0);
            else begin
                chk(out_data === exp_d[rd & 4095],
                    exp_k[rd & 4095] == 2'd3 ? "R6/R7" : "R5", out_data, exp_d[rd & 4095]);
                if (exp_k[rd & 4095] == 2'd3) last_field = out_data[31:0];
                rd++;
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
        took = v && in_ready;
        if (took) begin
            m = d[63:0];
            if (k == 2'd2) m[57:0] = '0;
            if (k == 2'd3) m[31:0] = '0;
            nx = crc_ref(k == 2'd1 ? 32'hFFFFFFFF : ref_crc, m);
            ref_crc = nx;
            exp_d[wr & 4095] = (k == 2'd3) ? {d[66:32], ~nx} : d;
            exp_k[wr & 4095] = k;
            wr++;
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [66:0] d, input bit gaps);
        bit t;
        if (gaps && rnd()[1:0] == 2'b00) cycle(1'b0, 2'd0, 67'(rnd()), t);
        t = 0;
        while (!t) cycle(1'b1, k, d, t);
    endtask

    task automatic drain();
        bit t;
        int n = 0;
        while (rd != wr && n < 300) begin cycle(1'b0, 2'd0, '0, t); n++; end
        if (rd != wr) chk(1'b0, "R3 missing output", '0, '0);
        cycle(1'b0, 2'd0, '0, t);
    endtask

    task automatic build(input int len);
        flen = len;
        for (int i = 0; i < len; i++) begin
            fw[i] = {rnd()[2:0], rnd()};
            fk[i] = (i == 0) ? 2'd1 : (i == 1) ? 2'd2 : (i == len - 1) ? 2'd3 : 2'd0;
        end
    endtask

    task automatic send_frame(input bit gaps);
        for (int i = 0; i < flen; i++) send(fk[i], fw[i], gaps);
    endtask

    task automatic restore();
        for (int i = 0; i < flen; i++) fw[i] = bw[i];
    endtask

    // Sends the current frame and returns the inserted field
    task automatic run_frame(input bit gaps, output logic [31:0] f);
        send_frame(gaps);
        drain();
        f = last_field;
    endtask

    initial begin
        logic [31:0] base_f, f;
        bit t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 in reset", 67'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 after reset", 67'(out_valid), '0);

        // Sweep of backpressure levels and metaframe lengths (R3..R7, R11, R12)
        foreach (stall_pct_list[s]) begin
            stall_pct = stall_pct_list[s];
            for (int len = 3; len <= 10; len++) begin
                for (int rep = 0; rep < 3; rep++) begin
                    build(len);
                    if (rep == 2) send(2'd0, {rnd()[2:0], rnd()}, stall_pct != 0);
                    send_frame(stall_pct != 0);
                end
            end
            drain();
        end

        // Directed exclusion checks, no stall
        stall_pct = 0;
        build(6);
        for (int i = 0; i < 6; i++) bw[i] = fw[i];
        run_frame(1'b0, base_f);

        for (int i = 0; i < 6; i++) fw[i][66:64] = fw[i][66:64] ^ 3'b101;
        run_frame(1'b0, f);
        chk(f == base_f, "R8 header bits ignored", 67'(f), 67'(base_f));
        restore();

        fw[1][57:0] = fw[1][57:0] ^ rnd()[57:0] ^ 58'h1;
        run_frame(1'b0, f);
        chk(f == base_f, "R9 scrambler state ignored", 67'(f), 67'(base_f));
        restore();

        fw[1][60] = ~fw[1][60];
        run_frame(1'b0, f);
        chk(f != base_f, "R9 scrambler upper bits covered", 67'(f), 67'(base_f));
        restore();

        fw[5][31:0] = ~fw[5][31:0];
        run_frame(1'b0, f);
        chk(f == base_f, "R10 check field ignored", 67'(f), 67'(base_f));
        restore();

        fw[5][45] = ~fw[5][45];
        run_frame(1'b0, f);
        chk(f != base_f, "R10 diag upper bits covered", 67'(f), 67'(base_f));
        restore();

        for (int b = 0; b < 64; b++) begin
            fw[2][b] = ~fw[2][b];
            run_frame(1'b0, f);
            chk(f != base_f, "R11 payload bit covered", 67'(f), 67'(base_f));
            restore();
        end

        fw[0][7] = ~fw[0][7];
        run_frame(1'b0, f);
        chk(f != base_f, "R11 sync bit covered", 67'(f), 67'(base_f));
        restore();

        stall_pct = 50;
        run_frame(1'b1, f);
        chk(f == base_f, "R12 gaps and stalls ignored", 67'(f), 67'(base_f));
        stall_pct = 0;

        send(2'd0, 67'(rnd()), 1'b0);
        send(2'd3, 67'(rnd()), 1'b0);
        run_frame(1'b0, f);
        chk(f == base_f, "R7 restart on sync", 67'(f), 67'(base_f));

        cycle(1'b0, 2'd0, '0, t);
        chk(out_valid === 1'b0, "R3 empty after bubble", 67'(out_valid), '0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int stall_pct_list [3] = '{0, 30, 65};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule